// File: doc/BRIEF.md
# Serial Byte Transmitter with Even Parity

This block turns one 8-bit word into an asynchronous serial frame on a single output line. It gives every bit the same length, counted in pulses of an external enable that runs at sixteen times the bit rate. Each frame has a low start bit, then the eight data bits from least significant to most significant, then an even-parity bit, then a high stop bit. The line stays high between frames.

The host raises a send command level. A synchronizer and rising-edge detector turn that level into one internal pulse. A command held high for any length of time therefore starts exactly one frame. The word is captured when the pulse is accepted, so the data input may change while the frame is being sent. A busy flag marks the whole frame. The block accepts a new command on the clock cycle after a stop bit ends, so frames can follow each other with no idle gap.

Top module: `uart_tx_parity`

## Requirements
- R1: While reset is high, and whenever no frame is in progress, `txd` is 1 and `busy` is 0.
- R2: A frame is one start bit of value 0, then data bit 0 through data bit 7, then the parity bit, then one stop bit of value 1. At the edge that starts a frame, `busy` rises and `txd` becomes 0 together.
- R3: Every bit of the frame is held on `txd` for exactly 16 pulses of `baud_tick`. `txd` changes only on a clock edge where `baud_tick` is high, or on the edge that starts a frame.
- R4: The parity bit is the XOR of the eight data bits, so the data plus parity always hold an even number of ones.
- R5: A `send_cmd` level held high for longer than a whole frame starts only one frame. Only a new 0-to-1 transition starts another.
- R6: A rising edge of `send_cmd` that arrives while `busy` is 1 is ignored. `tx_data` is captured when a frame is accepted, and later changes to it do not affect that frame.
- R7: When idle, a rising edge of `send_cmd` driven just after clock edge k makes `busy` and the start bit appear at edge k+3 (synchronizer depth plus one).
- R8: `busy` stays 1 from the start bit through the 16th tick of the stop bit. It falls on that edge and at no other point in the frame.
- R9: A send pulse on the cycle right after a stop bit ends starts the next start bit at once, with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle enable at 16x the bit rate |
| send_cmd | input | 1 | Send command level, any width, asynchronous |
| tx_data | input | 8 | Word to transmit, captured when a frame is accepted |
| txd | output | 1 | Serial output line, idle high |
| busy | output | 1 | High while a frame is on the line |

## Verification
The bench decodes the line by taking one sample of `txd` per tick. It requires each of the eleven bits to span exactly 16 identical samples, so a bit counter that is off by one, or a tick lost in the shift cycle, shows up as a misaligned group or wrong data. It holds the command high across several frame lengths and also sends a second edge in the middle of a frame. A design without the edge detect, or one that ignores `busy`, would send an extra frame, or would send the wrong data because the bench changes `tx_data` while the frame is running. In a run with a tick on every cycle, the bench times a command so that its pulse lands exactly one cycle after the stop bit. A design with an idle dead cycle would start that frame one edge late. Words with all zeros, all ones and a single one set check that the parity is even and not odd.

// File: rtl/uart_tx_parity_pkg.sv
`timescale 1ns/1ps
package uart_tx_parity_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_WAIT  = 3'd2,
    ST_SHIFT = 3'd3,
    ST_STOP  = 3'd4
  } txp_state_e;
endpackage

// File: rtl/txp_cmd_edge.sv
`timescale 1ns/1ps
module txp_cmd_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cmd_lvl,
  output logic cmd_pulse
);
  // SYNC_STAGES flops of synchronizer plus one history flop for edge detect
  logic [SYNC_STAGES:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-1:0], cmd_lvl};
  end

  assign cmd_pulse = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

  // R5
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_pulse |=> !cmd_pulse);
endmodule

// File: rtl/txp_parity.sv
`timescale 1ns/1ps
module txp_parity #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  output logic              par
);
  logic [DATA_W:0] chain;
  assign chain[0] = 1'b0;
  for (genvar i = 0; i < DATA_W; i++) begin : g_xor
    assign chain[i+1] = chain[i] ^ data[i];
  end
  assign par = chain[DATA_W];
endmodule

// File: rtl/txp_frame_fsm.sv
`timescale 1ns/1ps
module txp_frame_fsm
  import uart_tx_parity_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              start_pulse,
  input  logic [DATA_W-1:0] data,
  input  logic              par,
  output logic              txd,
  output logic              busy
);
  localparam int CNT_W = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam int BIT_W = $clog2(DATA_W + 2);
  localparam int SH_W  = DATA_W + 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TICKS_PER_BIT - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W + 1);

  txp_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [BIT_W-1:0]  bitn;
  logic [SH_W-1:0]   sh;
  logic              txd_q;
  logic              busy_q;
  logic              bit_end;

  assign bit_end = tick && (cnt == LAST_CNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitn   <= '0;
      sh     <= '0;
      txd_q  <= 1'b1;
      busy_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start_pulse) begin
            sh     <= {par, data};
            cnt    <= '0;
            bitn   <= '0;
            txd_q  <= 1'b0;
            busy_q <= 1'b1;
            state  <= ST_START;
          end
        end
        ST_START: begin
          if (bit_end) begin
            cnt   <= '0;
            txd_q <= sh[0];
            state <= ST_SHIFT;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_WAIT: begin
          if (bit_end) begin
            cnt <= '0;
            if (bitn == LAST_BIT) begin
              txd_q <= 1'b1;
              state <= ST_STOP;
            end else begin
              txd_q <= sh[0];
              state <= ST_SHIFT;
            end
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_SHIFT: begin
          sh    <= {1'b1, sh[SH_W-1:1]};
          bitn  <= bitn + 1'b1;
          cnt   <= {{(CNT_W-1){1'b0}}, tick};
          state <= ST_WAIT;
        end
        ST_STOP: begin
          if (bit_end) begin
            cnt    <= '0;
            busy_q <= 1'b0;
            state  <= ST_IDLE;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign txd  = txd_q;
  assign busy = busy_q;

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> txd_q);
  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> !txd_q);
  // R3
  line_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(txd_q) |-> ($past(tick) || $rose(busy_q)));
  // R6
  accept_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(start_pulse));
  // R8
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> ($past(state) == ST_STOP && $past(tick)));
endmodule

// File: rtl/uart_tx_parity.sv
`timescale 1ns/1ps
module uart_tx_parity #(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic              send_cmd,
  input  logic [DATA_W-1:0] tx_data,
  output logic              txd,
  output logic              busy
);
  logic send_pulse;
  logic par_bit;

  txp_cmd_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk       (clk),
    .rst       (rst),
    .cmd_lvl   (send_cmd),
    .cmd_pulse (send_pulse)
  );

  txp_parity #(.DATA_W(DATA_W)) u_par (
    .data (tx_data),
    .par  (par_bit)
  );

  txp_frame_fsm #(.DATA_W(DATA_W), .TICKS_PER_BIT(TICKS_PER_BIT)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .tick        (baud_tick),
    .start_pulse (send_pulse),
    .data        (tx_data),
    .par         (par_bit),
    .txd         (txd),
    .busy        (busy)
  );
endmodule

// File: tb/uart_tx_parity_tb.sv
`timescale 1ns/1ps
module uart_tx_parity_tb_top;
  localparam int SMP = 176;   // 11 bits x 16 ticks
  localparam int LAT = 3;     // edges from command to start bit

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic baud_tick = 1'b0;
  logic send_cmd = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic txd, busy;

  int checks = 0;
  int errors = 0;
  int gap_max = 4;
  bit done = 1'b0;

  uart_tx_parity dut_i (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .send_cmd(send_cmd),
    .tx_data(tx_data), .txd(txd), .busy(busy)
  );

  always #2 clk = ~clk;

  // tick generator: random spacing 1..gap_max
  initial begin
    forever begin
      int g;
      g = (gap_max <= 1) ? 1 : int'($urandom_range(1, gap_max));
      repeat (g - 1) begin @(posedge clk); #1 baud_tick = 1'b0; end
      @(posedge clk); #1 baud_tick = 1'b1;
    end
  end

  // line monitor: one sample per tick
  logic [SMP-1:0] smp;
  bit   collecting = 1'b0;
  int   idx = 0;
  int   frames = 0;
  logic [7:0] m_data;
  logic m_par, m_uniform, m_start, m_stop;

  always @(negedge clk) begin
    if (rst) collecting = 1'b0;
    else if (baud_tick) begin
      if (!collecting) begin
        if (txd == 1'b0) begin collecting = 1'b1; smp[0] = 1'b0; idx = 1; end
      end else begin
        smp[idx] = txd;
        idx++;
        if (idx == SMP) begin
          collecting = 1'b0;
          m_uniform = 1'b1;
          for (int b = 0; b < 11; b++)
            for (int s = 0; s < 16; s++)
              if (smp[b*16+s] !== smp[b*16]) m_uniform = 1'b0;
          for (int k = 0; k < 8; k++) m_data[k] = smp[(k+1)*16];
          m_par   = smp[144];
          m_start = smp[0];
          m_stop  = smp[160];
          frames++;
        end
      end
    end
  end

  function automatic logic exp_par(input logic [7:0] d);
    int ones = 0;
    for (int i = 0; i < 8; i++) if (d[i]) ones++;
    return (ones % 2) ? 1'b1 : 1'b0;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic check_frame(input logic [7:0] d, input int exp_frames);
    chk(frames == exp_frames, "R5", "frame count", frames, exp_frames);
    chk(m_uniform == 1'b1, "R3", "16 ticks per bit", m_uniform, 1);
    chk(m_start == 1'b0 && m_stop == 1'b1, "R2", "start/stop", {m_start, m_stop}, 1);
    chk(m_data == d, "R2", "data LSB first", m_data, d);
    chk(m_par == exp_par(d), "R4", "even parity", m_par, exp_par(d));
  endtask

  // raise command, measure latency to start bit (R7)
  task automatic launch(input logic [7:0] d);
    int n = 0;
    @(posedge clk); #1 send_cmd = 1'b1; tx_data = d;
    do begin @(negedge clk); n++; end while (!busy && n < 20);
    chk(n == LAT + 1, "R7", "start latency", n, LAT + 1);
    chk(txd == 1'b0, "R2", "start bit low", txd, 0);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic quiet_check(input int cyc, input string rq);
    bit rose = 1'b0;
    repeat (cyc) begin @(negedge clk); if (busy) rose = 1'b1; end
    chk(!rose, rq, "no extra frame", rose, 0);
  endtask

  initial begin
    int fexp;
    logic [7:0] d, d2;
    void'($urandom(32'd20240517));
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(txd == 1'b1, "R1", "txd in reset", txd, 1);
    chk(busy == 1'b0, "R1", "busy in reset", busy, 0);
    @(posedge clk); #1 rst = 1'b0;
    repeat (10) @(negedge clk);
    chk(txd == 1'b1 && busy == 1'b0, "R1", "idle after reset", {txd, busy}, 2);
    fexp = 0;

    // directed parity corners and random words
    for (int i = 0; i < 20; i++) begin
      case (i)
        0: d = 8'h00;  1: d = 8'hFF;  2: d = 8'h80;  3: d = 8'h01;
        default: d = 8'($urandom);
      endcase
      gap_max = (i % 3) + 2;
      launch(d);
      repeat ($urandom_range(1, 30)) @(posedge clk);
      #1 send_cmd = 1'b0; tx_data = 8'($urandom);   // R6 data change
      wait_idle();
      fexp++;
      check_frame(d, fexp);
      chk(txd == 1'b1, "R1", "idle line", txd, 1);
      repeat ($urandom_range(4, 20)) @(posedge clk);
    end

    // R5 held command
    gap_max = 2;
    launch(8'hA5);
    wait_idle();
    fexp++;
    check_frame(8'hA5, fexp);
    quiet_check(600, "R5");
    chk(frames == fexp, "R5", "held level one frame", frames, fexp);
    @(posedge clk); #1 send_cmd = 1'b0;
    repeat (10) @(posedge clk);

    // R6 edge during frame ignored, data captured
    launch(8'h3C);
    repeat (5) @(posedge clk); #1 send_cmd = 1'b0;
    repeat (150) @(posedge clk); #1 send_cmd = 1'b1; tx_data = 8'hC3;
    repeat (8) @(posedge clk); #1 send_cmd = 1'b0;
    wait_idle();
    fexp++;
    check_frame(8'h3C, fexp);
    quiet_check(300, "R6");
    chk(frames == fexp, "R6", "mid-frame edge ignored", frames, fexp);

    // R9 back-to-back with tick every cycle
    gap_max = 1;
    repeat (20) @(posedge clk);
    d = 8'h5A; d2 = 8'h96;
    @(posedge clk); #1 send_cmd = 1'b1; tx_data = d;
    repeat (LAT) @(posedge clk);          // now at edge E
    repeat (5) @(posedge clk); #1 send_cmd = 1'b0;
    repeat (169) @(posedge clk); #1 send_cmd = 1'b1; tx_data = d2; // edge E+174
    @(negedge clk);
    chk(busy == 1'b1, "R8", "busy in stop bit", busy, 1);
    @(negedge clk);
    chk(busy == 1'b1, "R8", "busy at last stop tick", busy, 1);
    @(negedge clk);                       // after E+176
    chk(busy == 1'b0, "R8", "busy falls at stop end", busy, 0);
    fexp++;
    check_frame(d, fexp);
    @(negedge clk);                       // after E+177
    chk(busy == 1'b1 && txd == 1'b0, "R9", "next start at once", {busy, txd}, 2);
    @(posedge clk); #1 send_cmd = 1'b0;
    wait_idle();
    fexp++;
    check_frame(d2, fexp);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule